// File: doc/BRIEF.md
# Transmit Collision Retry Controller

This block decides the fate of each frame attempt that a half-duplex Ethernet transmit engine makes. When the engine raises a frame request, the controller first waits for the medium to fall quiet (carrier sense low), then grants the attempt. During the attempt it counts transmitted bytes. If the media-independent interface reports a collision, it compares that count with a programmable window. An early collision leads to another attempt, after a randomised back-off, after carrier deferral only, or at once, as configured. A late collision, or one that takes the attempt count past the configured retry budget, abandons the frame.

Deferral time is measured in ticks supplied by the engine. Each tick is one bit time at 10 Mb/s or one nibble time at 100 Mb/s. A deferral that runs past the speed-dependent limit abandons the frame, unless indefinite deferral is selected. Every frame ends with a single-cycle completion pulse that carries a 16-bit status word. Serialisation, FCS generation and data buffering belong to the engine.

Top module: `tx_coll_retry`

## Requirements
- R1: After reset, go_o, retry_o and done_o are low and status_o is 0x0000.
- R2: After a frame request, go_o is withheld for as long as crs_i is high, and rises the cycle after crs_i is seen low. A frame that saw carrier while waiting reports bit 8 (deferred) set in its status.
- R3: A collision seen when the number of byte strobes in the current attempt is at most cfg_win_i is early. If the retry budget allows, retry_o pulses and the collision count (status bits 3:0) increases by one.
- R4: A collision after more than cfg_win_i bytes is late. It produces no retry and ends the frame with status bit 5 (late) and bit 14 (aborted) set. The collision count is left unchanged.
- R5: When an early collision brings the count above cfg_max_retry_i, the frame ends with bit 4 (retry limit) and bit 14 set. Bits 3:0 hold the collision count, saturated at 15.
- R6: With cfg_no_backoff_i set (and cfg_imm_retx_i clear), a retry skips the random wait and only defers to carrier. go_o follows one cycle after retry_o when the medium is idle.
- R7: With cfg_imm_retx_i set, go_o pulses in the same cycle as retry_o, without waiting for back-off or carrier.
- R8: Otherwise, after collision n the controller waits a random number of slots in [0, 2^min(n,10) − 1]. A slot is 512 ticks at 10 Mb/s (cfg_slow_i=1) or 128 ticks at 100 Mb/s, and go_o comes between 3 and 3 + 128·(2^n − 1) cycles (100 Mb/s, tick every cycle) after retry_o.
- R9: Carrier held through more than 6071 ticks (100 Mb/s) or 24287 ticks (10 Mb/s) of one deferral ends the frame with bits 7 (excessive deferral), 8 and 14 set.
- R10: With cfg_defer_inf_i set, deferral never aborts, and go_o follows once carrier drops.
- R11: end_i during an attempt ends the frame with status bit 14 clear. done_o is high for exactly one cycle, and status_o is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One bit time (10 Mb/s) or nibble time (100 Mb/s) has elapsed |
| sof_i | input | 1 | Engine requests a new frame (taken only when idle) |
| byte_i | input | 1 | One byte was put on the wire in the current attempt |
| end_i | input | 1 | Engine finished the current attempt cleanly |
| col_i | input | 1 | Collision reported by the PHY |
| crs_i | input | 1 | Carrier sensed on the medium |
| cfg_win_i | input | 6 | Last byte count at which a collision is still early |
| cfg_max_retry_i | input | 4 | Collisions allowed before the frame is abandoned |
| cfg_no_backoff_i | input | 1 | Retry after carrier deferral, no random wait |
| cfg_imm_retx_i | input | 1 | Retry at once, no wait and no deferral |
| cfg_defer_inf_i | input | 1 | Never abandon a frame for excessive deferral |
| cfg_slow_i | input | 1 | 10 Mb/s tick scaling (1) or 100 Mb/s (0) |
| go_o | output | 1 | Pulse: engine may start an attempt now |
| retry_o | output | 1 | Pulse: last attempt collided early and will be repeated |
| done_o | output | 1 | Pulse: frame finished or abandoned |
| status_o | output | 16 | Frame status word, valid with done_o |

## Verification
A corrupted byte counter moves the early/late boundary. That shows in the first collision probed one byte either side of cfg_win_i, as a retry where an abort was due or the reverse. A wrong collision counter shows in the status count field, or as a retry-limit abort one collision early or late. A stuck back-off or deferral timer shows as a missing go_o within the slot bound, or as an abort before or long after the deferral limit. A state register that leaks across frames shows as stale flags in the next status word.

// File: rtl/txcr_pkg.sv
package txcr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DEFER, ST_TX, ST_BACKOFF} txcr_state_e;

  localparam int STAT_W     = 16;
  localparam int CNT_W      = 5;
  localparam int BIT_MAXCOL = 4;
  localparam int BIT_LATE   = 5;
  localparam int BIT_XSDFR  = 7;
  localparam int BIT_DEFER  = 8;
  localparam int BIT_ABORT  = 14;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic [CNT_W-1:0] ncol, input logic maxc, input logic late,
    input logic xs, input logic dfr, input logic ab);
    logic [STAT_W-1:0] s;
    s = '0;
    s[3:0]        = (ncol > 5'd15) ? 4'hF : ncol[3:0];
    s[BIT_MAXCOL] = maxc;
    s[BIT_LATE]   = late;
    s[BIT_XSDFR]  = xs;
    s[BIT_DEFER]  = dfr;
    s[BIT_ABORT]  = ab;
    return s;
  endfunction
endpackage

// File: rtl/txcr_lfsr.sv
module txcr_lfsr #(
  parameter int          W    = 10,
  parameter logic [W-1:0] TAPS = 10'h240,
  parameter logic [W-1:0] SEED = 10'h1A5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= {1'b0, q[W-1:1]} ^ (q[0] ? TAPS : '0);
  end

  assign rnd_o = q;

  // R8: a stuck-at-zero generator would freeze back-off at zero slots
  p_lfsr_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni) q != '0);
endmodule

// File: rtl/txcr_backoff.sv
module txcr_backoff #(
  parameter int SLOT_BITS = 512,
  parameter int EXP_CAP   = 10,
  parameter int CNT_W     = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [CNT_W-1:0]   ncol_i,
  input  logic [EXP_CAP-1:0] rnd_i,
  input  logic               tick_i,
  input  logic               slow_i,
  output logic               expire_o
);
  localparam int TK_W = $clog2(SLOT_BITS);

  logic               run;
  logic [EXP_CAP-1:0] slots;
  logic [TK_W-1:0]    tk;
  logic [EXP_CAP-1:0] mask;
  logic [TK_W-1:0]    slot_last;

  always_comb begin
    mask = '0;
    for (int i = 0; i < EXP_CAP; i++)
      if (i < int'(ncol_i)) mask[i] = 1'b1;
  end

  assign slot_last = slow_i ? TK_W'(SLOT_BITS - 1) : TK_W'(SLOT_BITS / 4 - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run      <= 1'b0;
      slots    <= '0;
      tk       <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (start_i) begin
        run   <= 1'b1;
        slots <= rnd_i & mask;
        tk    <= '0;
      end else if (run) begin
        if (slots == '0) begin
          run      <= 1'b0;
          expire_o <= 1'b1;
        end else if (tick_i) begin
          if (tk == slot_last) begin
            tk    <= '0;
            slots <= slots - 1'b1;
          end else begin
            tk <= tk + 1'b1;
          end
        end
      end
    end
  end

  p_expire_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !expire_o);
  p_slots_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !start_i) |=> slots <= $past(slots));
endmodule

// File: rtl/txcr_defer.sv
module txcr_defer #(
  parameter int LIM_SER = 24287,
  parameter int LIM_NIB = 6071
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic count_i,
  input  logic clr_i,
  input  logic slow_i,
  output logic over_o
);
  localparam int DW = $clog2(LIM_SER + 2);

  logic [DW-1:0] cnt;
  logic [DW-1:0] lim;

  assign lim    = slow_i ? DW'(LIM_SER) : DW'(LIM_NIB);
  assign over_o = cnt > lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt <= '0;
    else if (clr_i)               cnt <= '0;
    else if (count_i && !over_o)  cnt <= cnt + 1'b1;
  end

  p_cnt_cap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= DW'(LIM_SER + 1));
endmodule

// File: rtl/tx_coll_retry.sv
module tx_coll_retry
  import txcr_pkg::*;
#(
  parameter int WIN_W     = 6,
  parameter int RETRY_W   = 4,
  parameter int SLOT_BITS = 512,
  parameter int EXP_CAP   = 10,
  parameter int LIM_SER   = 24287,
  parameter int LIM_NIB   = 6071
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bit_tick_i,
  input  logic               sof_i,
  input  logic               byte_i,
  input  logic               end_i,
  input  logic               col_i,
  input  logic               crs_i,
  input  logic [WIN_W-1:0]   cfg_win_i,
  input  logic [RETRY_W-1:0] cfg_max_retry_i,
  input  logic               cfg_no_backoff_i,
  input  logic               cfg_imm_retx_i,
  input  logic               cfg_defer_inf_i,
  input  logic               cfg_slow_i,
  output logic               go_o,
  output logic               retry_o,
  output logic               done_o,
  output logic [STAT_W-1:0]  status_o
);
  localparam int BC_W = WIN_W + 1;

  txcr_state_e        st;
  logic [CNT_W-1:0]   coll;
  logic [CNT_W-1:0]   ncoll;
  logic [BC_W-1:0]    bcnt;
  logic               dfr;
  logic               late;
  logic               over_lim;
  logic               bo_start;
  logic               bo_expire;
  logic               dly_over;
  logic [EXP_CAP-1:0] rnd;

  assign ncoll    = coll + 1'b1;
  assign late     = bcnt > BC_W'(cfg_win_i);
  assign over_lim = ncoll > CNT_W'(cfg_max_retry_i);
  assign bo_start = (st == ST_TX) && col_i && !late && !over_lim &&
                    !cfg_imm_retx_i && !cfg_no_backoff_i;

  txcr_lfsr #(.W(EXP_CAP), .TAPS(EXP_CAP'(10'h240)), .SEED(EXP_CAP'(10'h1A5))) u_lfsr (
    .clk_i, .rst_ni, .rnd_o(rnd)
  );

  txcr_backoff #(.SLOT_BITS(SLOT_BITS), .EXP_CAP(EXP_CAP), .CNT_W(CNT_W)) u_backoff (
    .clk_i, .rst_ni, .start_i(bo_start), .ncol_i(ncoll), .rnd_i(rnd),
    .tick_i(bit_tick_i), .slow_i(cfg_slow_i), .expire_o(bo_expire)
  );

  txcr_defer #(.LIM_SER(LIM_SER), .LIM_NIB(LIM_NIB)) u_defer (
    .clk_i, .rst_ni,
    .count_i(st == ST_DEFER && crs_i && bit_tick_i),
    .clr_i(st != ST_DEFER),
    .slow_i(cfg_slow_i), .over_o(dly_over)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st       <= ST_IDLE;
      coll     <= '0;
      bcnt     <= '0;
      dfr      <= 1'b0;
      go_o     <= 1'b0;
      retry_o  <= 1'b0;
      done_o   <= 1'b0;
      status_o <= '0;
    end else begin
      go_o    <= 1'b0;
      retry_o <= 1'b0;
      done_o  <= 1'b0;
      unique case (st)
        ST_IDLE: if (sof_i) begin
          st   <= ST_DEFER;
          coll <= '0;
          dfr  <= 1'b0;
        end
        ST_DEFER: begin
          if (crs_i) begin
            dfr <= 1'b1;
            if (dly_over && !cfg_defer_inf_i) begin
              done_o   <= 1'b1;
              status_o <= pack_status(coll, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
              st       <= ST_IDLE;
            end
          end else begin
            go_o <= 1'b1;
            bcnt <= '0;
            st   <= ST_TX;
          end
        end
        ST_TX: begin
          if (col_i) begin
            if (late) begin
              done_o   <= 1'b1;
              status_o <= pack_status(coll, 1'b0, 1'b1, 1'b0, dfr, 1'b1);
              st       <= ST_IDLE;
            end else if (over_lim) begin
              coll     <= ncoll;
              done_o   <= 1'b1;
              status_o <= pack_status(ncoll, 1'b1, 1'b0, 1'b0, dfr, 1'b1);
              st       <= ST_IDLE;
            end else begin
              coll    <= ncoll;
              retry_o <= 1'b1;
              if (cfg_imm_retx_i) begin
                go_o <= 1'b1;
                bcnt <= '0;
              end else if (cfg_no_backoff_i) begin
                st <= ST_DEFER;
              end else begin
                st <= ST_BACKOFF;
              end
            end
          end else if (end_i) begin
            done_o   <= 1'b1;
            status_o <= pack_status(coll, 1'b0, 1'b0, 1'b0, dfr, 1'b0);
            st       <= ST_IDLE;
          end else if (byte_i && bcnt != '1) begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_BACKOFF: if (bo_expire) st <= ST_DEFER;
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_no_go_on_carrier_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_DEFER && crs_i) |=> !go_o);
  p_late_no_retry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_TX && col_i && late) |=> (done_o && !retry_o));
  p_maxcol_abort_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o[BIT_MAXCOL]) |-> (status_o[BIT_ABORT] && status_o[3:0] != 4'h0));
  p_retry_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(retry_o && done_o));
  p_imm_go_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |-> (go_o == $past(cfg_imm_retx_i)));
endmodule

// File: tb/tb_tx_coll_retry.sv
`timescale 1ns/1ps
module tb_tx_coll_retry;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, sof = 1'b0, byt = 1'b0, eof = 1'b0, col = 1'b0, crs = 1'b0;
  logic [5:0] win = 6'd63;
  logic [3:0] maxr = 4'd15;
  logic nobo = 1'b0, imm = 1'b0, dinf = 1'b0, slow = 1'b0;
  logic go, retry, done;
  logic [15:0] status;
  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tx_coll_retry dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .sof_i(sof), .byte_i(byt),
    .end_i(eof), .col_i(col), .crs_i(crs), .cfg_win_i(win), .cfg_max_retry_i(maxr),
    .cfg_no_backoff_i(nobo), .cfg_imm_retx_i(imm), .cfg_defer_inf_i(dinf),
    .cfg_slow_i(slow), .go_o(go), .retry_o(retry), .done_o(done), .status_o(status)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_frame();
    sof = 1'b1; @(negedge clk); sof = 1'b0; @(negedge clk);
  endtask

  task automatic wait_go(input int lim, output int cyc);
    cyc = 0;
    while (!go && cyc < lim) begin @(negedge clk); cyc++; end
  endtask

  task automatic send_bytes(input int k);
    for (int i = 0; i < k; i++) begin byt = 1'b1; @(negedge clk); end
    byt = 1'b0;
  endtask

  task automatic collide(output logic r, output logic d, output logic [15:0] s, output logic g);
    col = 1'b1; @(negedge clk); col = 1'b0;
    r = retry; d = done; s = status; g = go;
  endtask

  task automatic end_frame(output logic d, output logic [15:0] s);
    eof = 1'b1; @(negedge clk); eof = 1'b0;
    d = done; s = status;
  endtask

  task automatic t_reset();
    chk(!go && !retry && !done && status == 16'h0, "R1 reset outputs", {go, retry, done, status}, 0);
  endtask

  task automatic t_clean();
    int c; logic d; logic [15:0] s;
    imm = 1'b1; start_frame(); wait_go(5, c);
    chk(go, "R11 grant", go, 1);
    send_bytes(20); end_frame(d, s);
    chk(d && s == 16'h0000, "R11 clean status", {d, s}, 32'h10000);
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
  endtask

  task automatic t_defer();
    int c; logic d; logic [15:0] s; bit seen = 0;
    crs = 1'b1; start_frame();
    for (int i = 0; i < 6; i++) begin if (go) seen = 1; @(negedge clk); end
    chk(!seen, "R2 no grant under carrier", seen, 0);
    crs = 1'b0; @(negedge clk);
    chk(go, "R2 grant cycle after carrier drop", go, 1);
    end_frame(d, s);
    chk(d && s == 16'h0100, "R2 deferred bit", s, 16'h0100);
  endtask

  task automatic t_window();
    int c; logic r, d, g; logic [15:0] s;
    imm = 1'b1; win = 6'd8; maxr = 4'd15;
    start_frame(); wait_go(5, c);
    send_bytes(7); collide(r, d, s, g);
    chk(r && !d, "R3 early below window", {r, d}, 2'b10);
    send_bytes(8); collide(r, d, s, g);
    chk(r && !d, "R3 early at window", {r, d}, 2'b10);
    send_bytes(9); collide(r, d, s, g);
    chk(!r && d && s == 16'h4022, "R4 late above window", {r, d, s}, {2'b01, 16'h4022});
    win = 6'd0; start_frame(); wait_go(5, c);
    collide(r, d, s, g);
    chk(r && !d, "R3 window zero, no bytes", {r, d}, 2'b10);
    send_bytes(1); collide(r, d, s, g);
    chk(!r && d && s == 16'h4021, "R4 window zero, one byte", s, 16'h4021);
    win = 6'd63;
  endtask

  task automatic t_max();
    int c; logic r, d, g; logic [15:0] s;
    imm = 1'b1; maxr = 4'd2; start_frame(); wait_go(5, c);
    for (int i = 0; i < 2; i++) begin
      collide(r, d, s, g);
      chk(r && !d, "R5 retry within budget", {r, d}, 2'b10);
    end
    collide(r, d, s, g);
    chk(d && !r && s == 16'h4013, "R5 budget exceeded", s, 16'h4013);
    maxr = 4'd0; start_frame(); wait_go(5, c);
    collide(r, d, s, g);
    chk(d && s == 16'h4011, "R5 zero budget", s, 16'h4011);
    maxr = 4'd15; start_frame(); wait_go(5, c);
    for (int i = 0; i < 15; i++) collide(r, d, s, g);
    chk(r && !d, "R5 fifteenth retry", {r, d}, 2'b10);
    collide(r, d, s, g);
    chk(d && s == 16'h401F, "R5 count saturates", s, 16'h401F);
  endtask

  task automatic t_imm();
    int c; logic r, d, g; logic [15:0] s;
    imm = 1'b1; nobo = 1'b0; start_frame(); wait_go(5, c);
    collide(r, d, s, g);
    chk(r && g, "R7 grant with retry", {r, g}, 2'b11);
    end_frame(d, s);
    chk(d && s == 16'h0001, "R7 count after retry", s, 16'h0001);
  endtask

  task automatic t_nobo();
    int c; logic r, d, g; logic [15:0] s; bit seen = 0;
    imm = 1'b0; nobo = 1'b1; start_frame(); wait_go(5, c);
    collide(r, d, s, g);
    chk(r && !g, "R6 no grant with retry", {r, g}, 2'b10);
    @(negedge clk);
    chk(go, "R6 grant next cycle", go, 1);
    crs = 1'b1; collide(r, d, s, g);
    for (int i = 0; i < 5; i++) begin if (go) seen = 1; @(negedge clk); end
    chk(r && !seen, "R6 defers to carrier", {r, seen}, 2'b10);
    crs = 1'b0; @(negedge clk);
    chk(go, "R6 grant after carrier", go, 1);
    end_frame(d, s);
    chk(d && s == 16'h0102, "R6 status", s, 16'h0102);
    nobo = 1'b0;
  endtask

  task automatic t_backoff();
    int c; logic r, d, g; logic [15:0] s;
    imm = 1'b0; nobo = 1'b0; slow = 1'b0; start_frame(); wait_go(5, c);
    for (int n = 1; n <= 3; n++) begin
      collide(r, d, s, g);
      wait_go(3 + 128 * ((1 << n) - 1) + 2, c);
      chk(r && !g && go && c >= 3 && c <= 3 + 128 * ((1 << n) - 1),
          "R8 back-off bound 100M", c, 3 + 128 * ((1 << n) - 1));
    end
    slow = 1'b1; collide(r, d, s, g);
    wait_go(3 + 512 * 15 + 2, c);
    chk(go && c >= 3 && c <= 3 + 512 * 15, "R8 back-off bound 10M", c, 3 + 512 * 15);
    slow = 1'b0;
    end_frame(d, s);
    chk(d && s == 16'h0004, "R8 status count", s, 16'h0004);
  endtask

  task automatic t_xsdfr(input logic sp, input int lim);
    bit seen = 0; int c;
    slow = sp; dinf = 1'b0; crs = 1'b1; start_frame();
    for (int i = 0; i < lim - 4; i++) begin if (done || go) seen = 1; @(negedge clk); end
    chk(!seen, "R9 no abort before limit", seen, 0);
    c = 0;
    while (!done && c < 40) begin @(negedge clk); c++; end
    chk(done && status == 16'h4180, "R9 excessive deferral", status, 16'h4180);
    crs = 1'b0; slow = 1'b0; @(negedge clk);
  endtask

  task automatic t_definf();
    bit seen = 0; int c; logic d; logic [15:0] s;
    dinf = 1'b1; crs = 1'b1; start_frame();
    for (int i = 0; i < 7000; i++) begin if (done || go) seen = 1; @(negedge clk); end
    chk(!seen, "R10 no abort", seen, 0);
    crs = 1'b0; wait_go(3, c);
    chk(go, "R10 grant after long carrier", go, 1);
    end_frame(d, s);
    chk(d && s == 16'h0100, "R10 status", s, 16'h0100);
    dinf = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_defer();
    t_window();
    t_max();
    t_imm();
    t_nobo();
    t_backoff();
    t_xsdfr(1'b0, 6071);
    t_xsdfr(1'b1, 24287);
    t_definf();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule